// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block takes single-word writes to a command register and turns each one into an action on one processor core. A two-bit kind field selects the action. The block can post an interrupt vector to a core, apply a power-on reset and then let the core run, put a core into an idle state that does not wake on interrupts, or bring an idle core back into service.

The block drives three kinds of output. Each core has a one-cycle reset pulse and a halt level. A shared post channel gives a one-cycle valid pulse together with the target core and the vector. A command that names a core at or above the number of present cores is discarded without any trace. A reset command that carries any vector other than the power-on code changes no core state. It sets a sticky error flag instead. The block accepts at most one command per cycle. The core count and the power-on code are parameters.

Top module: `ipc_dispatch`

## Requirements
- R1: While `cmd_we` is high, the command word is decoded as follows: bits 17:16 are the kind, bits 12:8 are the target core and bits 5:0 are the vector. Kind 0 (post) gives `post_valid` high for exactly the cycle after the write, with `post_core` equal to the target and `post_vec` equal to the vector.
- R2: Kind 1 (reset) with vector equal to `POR_VEC` pulses `core_rst[target]` for exactly the cycle after the write and clears `core_halt[target]`, so the core runs afterwards.
- R3: Kind 2 (idle) sets `core_halt[target]`. A kind 0 post to a halted core still appears on the post channel, but it leaves the halt set.
- R4: Kind 3 (resume) clears `core_halt[target]`.
- R5: A command whose target is greater than or equal to `NUM_CORES` changes no output, and this includes the error flag.
- R6: Kind 1 with a vector other than `POR_VEC` sets `reset_err`, produces no reset pulse and leaves every halt level unchanged.
- R7: `reset_err` stays set until `rst_n` is asserted.
- R8: After reset, all reset pulses, all halt levels, `post_valid` and `reset_err` are 0.
- R9: When `cmd_we` is low, no output changes, whatever value `cmd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | CMD_W | Command word |
| core_rst | output | NUM_CORES | One-cycle reset pulse per core |
| core_halt | output | NUM_CORES | Halt level per core |
| post_valid | output | 1 | Interrupt post valid pulse |
| post_core | output | 5 | Core that receives the post |
| post_vec | output | 6 | Posted vector |
| reset_err | output | 1 | Sticky flag for a reset with an unsupported vector |

## Verification
The hardest case to reach from the ports is a bad-vector reset aimed at an absent core. It must be dropped by the target check before the vector check can raise the error. The sweep therefore walks the core numbers downward. Every absent core receives a bad reset while the error flag is still clear, and only after that does a present core receive one. A post to an idle core is issued inside each core's sequence, so the halt level is checked as it survives the interrupt.

// File: rtl/ipc_dispatch_pkg.sv
package ipc_dispatch_pkg;
  localparam int KIND_LSB = 16;
  localparam int CORE_LSB = 8;
  localparam int CORE_W   = 5;
  localparam int VEC_W    = 6;

  typedef enum logic [1:0] {
    KIND_POST   = 2'd0,
    KIND_RESET  = 2'd1,
    KIND_IDLE   = 2'd2,
    KIND_RESUME = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/ipc_cmd_decode.sv
module ipc_cmd_decode
  import ipc_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CMD_W = 32,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic                 we,
  input  logic [CMD_W-1:0]     data,
  output logic                 do_post,
  output logic                 do_rst,
  output logic                 do_idle,
  output logic                 do_resume,
  output logic                 bad_rst,
  output logic [CORE_W-1:0]    tgt,
  output logic [VEC_W-1:0]     vec,
  output logic [NUM_CORES-1:0] sel
);
  cmd_kind_e kind;
  logic      present;

  always_comb begin
    kind      = cmd_kind_e'(data[KIND_LSB +: 2]);
    tgt       = data[CORE_LSB +: CORE_W];
    vec       = data[VEC_W-1:0];
    present   = we && (int'(tgt) < NUM_CORES);
    do_post   = present && (kind == KIND_POST);
    do_rst    = present && (kind == KIND_RESET) && (vec == POR_VEC);
    bad_rst   = present && (kind == KIND_RESET) && (vec != POR_VEC);
    do_idle   = present && (kind == KIND_IDLE);
    do_resume = present && (kind == KIND_RESUME);
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
    assign sel[i] = present && (tgt == CORE_W'(i));
  end
endmodule

// File: rtl/ipc_core_slot.sv
module ipc_core_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic do_rst,
  input  logic do_idle,
  input  logic do_resume,
  output logic rst_pulse,
  output logic halt
);
  logic halt_d, pulse_d, halt_en;

  always_comb begin
    halt_en = sel && (do_rst || do_idle || do_resume);
    halt_d  = do_idle;
    pulse_d = sel && do_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt      <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= pulse_d;
      if (halt_en) halt <= halt_d;
    end
  end

  assert_rst_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !halt);
  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse || $past(sel && do_rst));
endmodule

// File: rtl/ipc_dispatch.sv
module ipc_dispatch
  import ipc_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CMD_W = 32,
  parameter logic [5:0] POR_VEC = 6'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_data,
  output logic [NUM_CORES-1:0] core_rst,
  output logic [NUM_CORES-1:0] core_halt,
  output logic                 post_valid,
  output logic [4:0]           post_core,
  output logic [5:0]           post_vec,
  output logic                 reset_err
);
  logic                 do_post, do_rst, do_idle, do_resume, bad_rst;
  logic [CORE_W-1:0]    tgt;
  logic [VEC_W-1:0]     vec;
  logic [NUM_CORES-1:0] sel;
  logic                 err_d;

  ipc_cmd_decode #(.NUM_CORES(NUM_CORES), .CMD_W(CMD_W), .POR_VEC(POR_VEC)) u_dec (
    .we(cmd_we), .data(cmd_data), .do_post(do_post), .do_rst(do_rst),
    .do_idle(do_idle), .do_resume(do_resume), .bad_rst(bad_rst),
    .tgt(tgt), .vec(vec), .sel(sel)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    ipc_core_slot u_slot (
      .clk(clk), .rst_n(rst_n), .sel(sel[i]), .do_rst(do_rst),
      .do_idle(do_idle), .do_resume(do_resume),
      .rst_pulse(core_rst[i]), .halt(core_halt[i])
    );
  end

  always_comb err_d = reset_err || bad_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_core  <= '0;
      post_vec   <= '0;
      reset_err  <= 1'b0;
    end else begin
      post_valid <= do_post;
      reset_err  <= err_d;
      if (do_post) begin
        post_core <= tgt;
        post_vec  <= vec;
      end
    end
  end

  assert_post_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> $past(cmd_we));
  assert_post_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> (int'(post_core) < NUM_CORES));
  assert_single_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_rst));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_err |=> reset_err);
  assert_quiet_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_we) |-> ($stable(core_halt) && core_rst == '0 && !post_valid));
  assert_bad_reset_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_err) |-> core_rst == '0 && $stable(core_halt));
endmodule

// File: tb/tb_ipc_dispatch.sv
module tb_ipc_dispatch;
  localparam int NC = 4;
  localparam logic [5:0] POR = 6'h01;

  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [NC-1:0] core_rst, core_halt;
  logic post_valid, reset_err;
  logic [4:0] post_core;
  logic [5:0] post_vec;

  int checks = 0, fails = 0;
  logic [NC-1:0] m_halt = '0;
  logic m_err = 1'b0;

  always #2 clk = ~clk;

  ipc_dispatch #(.NUM_CORES(NC), .CMD_W(32), .POR_VEC(POR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .core_rst(core_rst), .core_halt(core_halt), .post_valid(post_valid),
    .post_core(post_core), .post_vec(post_vec), .reset_err(reset_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int kind, input int core, input logic [5:0] vec, input string req);
    logic present, good_rst;
    logic [NC-1:0] exp_rst;
    present  = core < NC;
    good_rst = present && kind == 1 && vec == POR;
    exp_rst  = good_rst ? NC'(1 << core) : '0;
    if (present) begin
      if (kind == 2) m_halt[core] = 1'b1;
      if (kind == 3 || good_rst) m_halt[core] = 1'b0;
      if (kind == 1 && !good_rst) m_err = 1'b1;
    end
    cmd_data = 32'(kind) << 16 | 32'(core) << 8 | 32'(vec);
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk({req, " post_valid"}, 32'(post_valid), 32'(present && kind == 0));
    if (present && kind == 0) begin
      chk({req, " post_core R1"}, 32'(post_core), 32'(core));
      chk({req, " post_vec R1"}, 32'(post_vec), 32'(vec));
    end
    chk({req, " core_rst"}, 32'(core_rst), 32'(exp_rst));
    chk({req, " core_halt"}, 32'(core_halt), 32'(m_halt));
    chk({req, " reset_err"}, 32'(reset_err), 32'(m_err));
    @(negedge clk);
    chk("R1 R2 pulses end", 32'({post_valid, core_rst}), 32'(0));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset state", 32'({core_rst, core_halt, post_valid, reset_err}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 7; c >= 0; c--) begin
      string r;
      r = (c >= NC) ? "R5" : "R1-R4";
      send(2, c, 6'h00, (c >= NC) ? "R5 idle" : "R3 idle");
      send(0, c, 6'(c * 7 + 3), (c >= NC) ? "R5 post" : "R3 post to idle");
      send(3, c, 6'h00, (c >= NC) ? "R5 resume" : "R4 resume");
      send(0, c, 6'h3f - 6'(c), (c >= NC) ? "R5 post" : "R1 post");
      send(2, c, 6'h00, (c >= NC) ? "R5 idle" : "R3 idle again");
      send(1, c, POR, (c >= NC) ? "R5 reset" : "R2 reset");
      send(1, c, 6'h2a, (c >= NC) ? "R5 bad reset" : "R6 bad reset");
      if (r.len() == 0) chk("unused", 0, 1);
    end
    send(2, 1, 6'h00, "R3 idle after err");
    send(1, 1, 6'h05, "R6 bad reset keeps halt");
    cmd_data = {14'h0, 2'd1, 3'h0, 5'd0, 2'h0, POR};
    repeat (3) @(negedge clk);
    chk("R9 no write", 32'({core_rst, core_halt, post_valid, reset_err}),
        32'({4'b0, m_halt, 1'b0, 1'b1}));
    chk("R7 sticky", 32'(reset_err), 32'(1));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_halt = '0;
    m_err = 1'b0;
    @(negedge clk);
    chk("R7 cleared by reset", 32'(reset_err), 32'(0));
    chk("R8 halt after reset", 32'(core_halt), 32'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule